// File: doc/BRIEF.md
# Multi-Mode Timer Output Compare Channel

This block is one output compare channel. It watches the count of one of two free-running timers and drives a single output pin from that count. A select bit picks the timer. A 3-bit mode field picks the behaviour: idle, a level change on one match (set, clear or toggle), a pulse between two compare values (once, or repeated every period), or pulse-width modulation. PWM can run with or without a fault input. Every compare or PWM event raises a one-cycle interrupt pulse.

The timers, the register interface and power-state handling live outside the block. The surrounding logic supplies the two counts, each timer's period-end strobe, the mode, a primary and a secondary compare value, and two active-low fault lines. A channel-index parameter decides which fault line the channel obeys.

Top module: `oc_channel`

## Requirements
- R1: When `tb_sel` is 0 the comparisons use `tmr_a_cnt` and `tmr_a_wrap`; when it is 1 they use `tmr_b_cnt` and `tmr_b_wrap`.
- R2: After reset, `pin`, `pin_oe` and `irq_pulse` are all 0.
- R3: In the first cycle in which `mode` differs from the value seen on the previous clock edge, the output level is cleared to 0. The one-pulse-done state, the duty value and the fault flag are also cleared, no event fires, and the new mode acts from the following cycle.
- R4: Mode 001 drives the level high, mode 010 drives it low, and mode 011 inverts it, each in the cycle after the selected count equals `cmp_pri`. Each such match pulses `irq_pulse` for one cycle.
- R5: In mode 000, `pin`, `pin_oe` and `irq_pulse` stay 0.
- R6: In modes 100 and 101, a low level goes high one cycle after the count equals `cmp_pri`. A high level goes low one cycle after the count equals `cmp_sec`, and that falling edge pulses `irq_pulse`.
- R7: Mode 100 makes exactly one pulse. After the falling edge the pin stays low, whatever the count does, until the mode changes.
- R8: In modes 110 and 111, each period strobe copies `cmp_sec` into the duty register. The same strobe drives the level high when that value is non-zero and pulses `irq_pulse`. Outside a strobe, the level goes low when the count equals the held duty value. A duty of 0 keeps the pin low for the whole period, and the strobe has priority over the duty match.
- R9: In mode 111, a low sampled fault line forces the level low at that edge and sets a fault flag. From the next cycle `pin_oe` and `pin` are 0. The flag holds until the mode changes.
- R10: A channel with `CH_IDX` from 1 to 4 obeys `fault_a_n`, and one with `CH_IDX` from 5 to 8 obeys `fault_b_n`. In mode 110, and in every other mode, the fault lines have no effect.
- R11: In every mode other than 000, with no fault flag set, `pin_oe` is 1 and `pin` shows the output level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_a_cnt | input | CNT_W | Count of timebase A |
| tmr_b_cnt | input | CNT_W | Count of timebase B |
| tmr_a_wrap | input | 1 | Period-end strobe of timebase A |
| tmr_b_wrap | input | 1 | Period-end strobe of timebase B |
| tb_sel | input | 1 | Timebase select (0 = A, 1 = B) |
| mode | input | 3 | Operating mode |
| cmp_pri | input | CNT_W | Primary compare value |
| cmp_sec | input | CNT_W | Secondary compare value / PWM duty source |
| fault_a_n | input | 1 | Active-low fault line A |
| fault_b_n | input | 1 | Active-low fault line B |
| pin | output | 1 | Output pin level |
| pin_oe | output | 1 | Output pin drive enable |
| irq_pulse | output | 1 | One-cycle event pulse |

## Verification
The bench builds two copies with `CNT_W` = 8, one with `CH_IDX` = 6 (`uut`) and one with `CH_IDX` = 2. Both get the same stimulus, so a single fault pulse shows one channel latching a fault while the other ignores it, which covers both fault-source variants in one run. The narrow count, together with short bench timer periods of 19 and 11, makes the following cases come up within a few dozen cycles:
- period strobes;
- compare values beyond one timer's reach but inside the other's;
- duties longer than the period.

// File: rtl/oc_pkg.sv
package oc_pkg;

    typedef enum logic [2:0] {
        OC_OFF     = 3'b000,
        OC_HI      = 3'b001,
        OC_LO      = 3'b010,
        OC_TGL     = 3'b011,
        OC_ONESHOT = 3'b100,
        OC_TRAIN   = 3'b101,
        OC_PWM     = 3'b110,
        OC_PWMF    = 3'b111
    } oc_mode_e;

    // Next-state drive produced by the event logic.
    typedef struct packed {
        logic lvl;
        logic irq;
    } oc_drive_t;

    function automatic logic uses_fault_b(input int unsigned idx);
        return idx >= 5;
    endfunction

    function automatic logic is_pwm(input oc_mode_e m);
        return (m == OC_PWM) || (m == OC_PWMF);
    endfunction

    function automatic logic is_dual(input oc_mode_e m);
        return (m == OC_ONESHOT) || (m == OC_TRAIN);
    endfunction

endpackage

// File: rtl/oc_timebase_sel.sv
module oc_timebase_sel #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt_a,
    input  logic [CNT_W-1:0] cnt_b,
    input  logic             wrap_a,
    input  logic             wrap_b,
    input  logic             sel,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    assign cnt  = sel ? cnt_b  : cnt_a;
    assign wrap = sel ? wrap_b : wrap_a;
endmodule

// File: rtl/oc_mode_track.sv
module oc_mode_track
    import oc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic [2:0] mode_in,
    output oc_mode_e mode_q,
    output logic     mode_chg
);
    always_ff @(posedge clk) begin
        if (rst) mode_q <= OC_OFF;
        else     mode_q <= oc_mode_e'(mode_in);
    end

    assign mode_chg = (mode_in != mode_q);
endmodule

// File: rtl/oc_fault_guard.sv
module oc_fault_guard
    import oc_pkg::*;
#(
    parameter int unsigned CH_IDX = 1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     fault_a_n,
    input  logic     fault_b_n,
    input  oc_mode_e mode_q,
    input  logic     mode_chg,
    output logic     fault_now,
    output logic     fault_flag
);
    localparam logic USE_B = uses_fault_b(CH_IDX);

    logic src_n;
    assign src_n     = USE_B ? fault_b_n : fault_a_n;
    assign fault_now = (mode_q == OC_PWMF) && !mode_chg && !src_n;

    always_ff @(posedge clk) begin
        if (rst)            fault_flag <= 1'b0;
        else if (mode_chg)  fault_flag <= 1'b0;
        else if (fault_now) fault_flag <= 1'b1;
    end

    assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (fault_flag && !mode_chg) |=> fault_flag);

    assert_fault_cleared_R3: assert property (@(posedge clk) disable iff (rst)
        mode_chg |=> !fault_flag);
endmodule

// File: rtl/oc_event_gen.sv
module oc_event_gen
    import oc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  oc_mode_e         mode_q,
    input  logic             mode_chg,
    input  logic [CNT_W-1:0] cnt,
    input  logic             wrap,
    input  logic [CNT_W-1:0] cmp_pri,
    input  logic [CNT_W-1:0] cmp_sec,
    input  logic             latch_q,
    input  logic             fault_now,
    input  logic             fault_flag,
    output oc_drive_t        drv_d
);
    logic [CNT_W-1:0] duty_q, duty_d;
    logic             done_q, done_d;
    logic             hit_pri, hit_sec, hit_duty;

    assign hit_pri  = (cnt == cmp_pri);
    assign hit_sec  = (cnt == cmp_sec);
    assign hit_duty = (cnt == duty_q);

    always_comb begin
        drv_d.lvl = latch_q;
        drv_d.irq = 1'b0;
        duty_d    = duty_q;
        done_d    = done_q;
        if (mode_chg) begin
            drv_d.lvl = 1'b0;
            duty_d    = '0;
            done_d    = 1'b0;
        end else begin
            unique case (mode_q)
                OC_OFF: drv_d.lvl = 1'b0;
                OC_HI: if (hit_pri) begin
                    drv_d.lvl = 1'b1;
                    drv_d.irq = 1'b1;
                end
                OC_LO: if (hit_pri) begin
                    drv_d.lvl = 1'b0;
                    drv_d.irq = 1'b1;
                end
                OC_TGL: if (hit_pri) begin
                    drv_d.lvl = !latch_q;
                    drv_d.irq = 1'b1;
                end
                OC_ONESHOT, OC_TRAIN: if (!done_q) begin
                    if (latch_q && hit_sec) begin
                        drv_d.lvl = 1'b0;
                        drv_d.irq = 1'b1;
                        if (mode_q == OC_ONESHOT) done_d = 1'b1;
                    end else if (!latch_q && hit_pri) begin
                        drv_d.lvl = 1'b1;
                    end
                end
                OC_PWM, OC_PWMF: if (wrap) begin
                    duty_d    = cmp_sec;
                    drv_d.lvl = (cmp_sec != '0);
                    drv_d.irq = 1'b1;
                end else if (hit_duty) begin
                    drv_d.lvl = 1'b0;
                end
            endcase
            if (fault_now || fault_flag) drv_d.lvl = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            duty_q <= '0;
            done_q <= 1'b0;
        end else begin
            duty_q <= duty_d;
            done_q <= done_d;
        end
    end

    assert_oneshot_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_q == OC_ONESHOT && done_q && !mode_chg) |=> !latch_q);

    assert_pwm_zero_duty_R8: assert property (@(posedge clk) disable iff (rst)
        (is_pwm(mode_q) && !mode_chg && wrap && cmp_sec == '0) |=> !latch_q);

    assert_dual_rise_R6: assert property (@(posedge clk) disable iff (rst)
        (is_dual(mode_q) && !mode_chg && !done_q && !latch_q && hit_pri) |=> latch_q);
endmodule

// File: rtl/oc_channel.sv
module oc_channel
    import oc_pkg::*;
#(
    parameter int          CNT_W  = 16,
    parameter int unsigned CH_IDX = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] tmr_a_cnt,
    input  logic [CNT_W-1:0] tmr_b_cnt,
    input  logic             tmr_a_wrap,
    input  logic             tmr_b_wrap,
    input  logic             tb_sel,
    input  logic [2:0]       mode,
    input  logic [CNT_W-1:0] cmp_pri,
    input  logic [CNT_W-1:0] cmp_sec,
    input  logic             fault_a_n,
    input  logic             fault_b_n,
    output logic             pin,
    output logic             pin_oe,
    output logic             irq_pulse
);
    logic [CNT_W-1:0] cnt;
    logic             wrap;
    oc_mode_e         mode_q;
    logic             mode_chg;
    logic             fault_now, fault_flag;
    oc_drive_t        drv_d;
    logic             latch_q, irq_q;

    oc_timebase_sel #(.CNT_W(CNT_W)) u_tb (
        .cnt_a (tmr_a_cnt), .cnt_b (tmr_b_cnt),
        .wrap_a(tmr_a_wrap), .wrap_b(tmr_b_wrap),
        .sel   (tb_sel), .cnt(cnt), .wrap(wrap)
    );

    oc_mode_track u_mode (
        .clk(clk), .rst(rst), .mode_in(mode),
        .mode_q(mode_q), .mode_chg(mode_chg)
    );

    oc_fault_guard #(.CH_IDX(CH_IDX)) u_fault (
        .clk(clk), .rst(rst),
        .fault_a_n(fault_a_n), .fault_b_n(fault_b_n),
        .mode_q(mode_q), .mode_chg(mode_chg),
        .fault_now(fault_now), .fault_flag(fault_flag)
    );

    oc_event_gen #(.CNT_W(CNT_W)) u_evt (
        .clk(clk), .rst(rst),
        .mode_q(mode_q), .mode_chg(mode_chg),
        .cnt(cnt), .wrap(wrap),
        .cmp_pri(cmp_pri), .cmp_sec(cmp_sec),
        .latch_q(latch_q),
        .fault_now(fault_now), .fault_flag(fault_flag),
        .drv_d(drv_d)
    );

    // Set/reset output latch and event pulse register.
    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            latch_q <= drv_d.lvl;
            irq_q   <= drv_d.irq;
        end
    end

    assign pin_oe    = (mode_q != OC_OFF) && !fault_flag;
    assign pin       = latch_q && pin_oe;
    assign irq_pulse = irq_q;

    assert_modechg_clears_R3: assert property (@(posedge clk) disable iff (rst)
        mode_chg |=> (!pin && !irq_pulse));

    assert_off_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_q == OC_OFF) |-> (!pin && !pin_oe && !irq_pulse));

    assert_fault_blocks_oe_R9: assert property (@(posedge clk) disable iff (rst)
        fault_now |=> (!pin && !pin_oe));

    assert_set_match_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_q == OC_HI && !mode_chg && cnt == cmp_pri) |=> (pin && irq_pulse));
endmodule

// File: tb/oc_channel_test.sv
module oc_channel_test;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 8;
    localparam int PA = 19;
    localparam int PB = 11;

    typedef struct packed {
        logic       latch;
        logic       irq;
        logic       done;
        logic       fflag;
        logic [2:0] mq;
        logic [W-1:0] duty;
    } mdl_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] cnt_a = '0, cnt_b = '0, pri = '0, sec = '0;
    logic wrap_a = 1'b0, wrap_b = 1'b0, sel = 1'b0;
    logic [2:0] md = 3'b000;
    logic fa_n = 1'b1, fb_n = 1'b1;
    logic pin0, oe0, irq0, pin1, oe1, irq1;

    int checks = 0;
    int fails  = 0;
    mdl_t m0, m1;

    always #(CLK_PERIOD/2) clk = ~clk;

    oc_channel #(.CNT_W(W), .CH_IDX(6)) uut (
        .clk(clk), .rst(rst), .tmr_a_cnt(cnt_a), .tmr_b_cnt(cnt_b),
        .tmr_a_wrap(wrap_a), .tmr_b_wrap(wrap_b), .tb_sel(sel), .mode(md),
        .cmp_pri(pri), .cmp_sec(sec), .fault_a_n(fa_n), .fault_b_n(fb_n),
        .pin(pin0), .pin_oe(oe0), .irq_pulse(irq0)
    );

    oc_channel #(.CNT_W(W), .CH_IDX(2)) uut2 (
        .clk(clk), .rst(rst), .tmr_a_cnt(cnt_a), .tmr_b_cnt(cnt_b),
        .tmr_a_wrap(wrap_a), .tmr_b_wrap(wrap_b), .tb_sel(sel), .mode(md),
        .cmp_pri(pri), .cmp_sec(sec), .fault_a_n(fa_n), .fault_b_n(fb_n),
        .pin(pin1), .pin_oe(oe1), .irq_pulse(irq1)
    );

    // Expected next state from the requirements.
    function automatic mdl_t mdl_next(mdl_t s, logic [2:0] mode_in, logic flt_n);
        mdl_t n = s;
        logic [W-1:0] c = sel ? cnt_b : cnt_a;
        logic w = sel ? wrap_b : wrap_a;
        n.irq = 1'b0;
        n.mq  = mode_in;
        if (mode_in != s.mq) begin
            n.latch = 1'b0; n.done = 1'b0; n.duty = '0; n.fflag = 1'b0;
            return n;
        end
        case (s.mq)
            3'd0: n.latch = 1'b0;
            3'd1: if (c == pri) begin n.latch = 1'b1; n.irq = 1'b1; end
            3'd2: if (c == pri) begin n.latch = 1'b0; n.irq = 1'b1; end
            3'd3: if (c == pri) begin n.latch = !s.latch; n.irq = 1'b1; end
            3'd4, 3'd5: if (!s.done) begin
                if (s.latch && c == sec) begin
                    n.latch = 1'b0; n.irq = 1'b1;
                    if (s.mq == 3'd4) n.done = 1'b1;
                end else if (!s.latch && c == pri) n.latch = 1'b1;
            end
            default: if (w) begin
                n.duty = sec; n.latch = (sec != '0); n.irq = 1'b1;
            end else if (c == s.duty) n.latch = 1'b0;
        endcase
        if (s.mq == 3'd7 && (!flt_n || s.fflag)) begin
            n.latch = 1'b0; n.fflag = 1'b1;
        end
        return n;
    endfunction

    function automatic logic [2:0] mdl_out(mdl_t s);
        logic oe = (s.mq != 3'd0) && !s.fflag;
        return {s.latch && oe, oe, s.irq};
    endfunction

    task automatic check_out(string tag);
        logic [2:0] e0 = mdl_out(m0);
        logic [2:0] e1 = mdl_out(m1);
        checks++;
        if ({pin0, oe0, irq0} !== e0) begin
            fails++;
            $display("FAIL %s uut {pin,oe,irq} actual=%b expected=%b t=%0t", tag, {pin0, oe0, irq0}, e0, $time);
        end
        checks++;
        if ({pin1, oe1, irq1} !== e1) begin
            fails++;
            $display("FAIL %s uut2 {pin,oe,irq} actual=%b expected=%b t=%0t", tag, {pin1, oe1, irq1}, e1, $time);
        end
    endtask

    // Called at a falling edge: advance timers, predict, then check at the next falling edge.
    task automatic run(int n, string tag);
        for (int i = 0; i < n; i++) begin
            string t = (md != m0.mq) ? "R3" : tag;
            wrap_a = (cnt_a == W'(PA));
            wrap_b = (cnt_b == W'(PB));
            cnt_a  = wrap_a ? '0 : cnt_a + 1'b1;
            cnt_b  = wrap_b ? '0 : cnt_b + 1'b1;
            wrap_a = (cnt_a == W'(PA));
            wrap_b = (cnt_b == W'(PB));
            m0 = mdl_next(m0, md, fb_n);
            m1 = mdl_next(m1, md, fa_n);
            @(negedge clk);
            check_out(t);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m0 = '0;
        m1 = '0;
        repeat (3) @(negedge clk);
        check_out("R2");
        rst = 1'b0;
        run(2, "R2");

        // R1: compare value 15 only reachable on timebase A
        md = 3'd3; pri = 8'd15; sel = 1'b1;
        run(40, "R1");
        sel = 1'b0;
        run(45, "R1");

        // R4 single-match modes
        md = 3'd1; pri = 8'd5;  run(30, "R4");
        md = 3'd2; pri = 8'd9;  run(30, "R4");
        md = 3'd3; pri = 8'd2;  run(50, "R4");
        md = 3'd3; sel = 1'b1; pri = 8'd4; run(40, "R4");

        // R5 disabled
        md = 3'd0; run(30, "R5");

        // R6 continuous dual pulses, both orders
        sel = 1'b0; md = 3'd5; pri = 8'd3; sec = 8'd12; run(70, "R6");
        md = 3'd5; pri = 8'd14; sec = 8'd6; run(60, "R6");

        // R7 one pulse then hold
        md = 3'd4; pri = 8'd4; sec = 8'd10; run(80, "R7");
        md = 3'd0; run(2, "R3");
        md = 3'd4; run(40, "R7");

        // R8 PWM: normal, zero, longer than period
        md = 3'd6; sec = 8'd9; run(50, "R8");
        sec = 8'd0;  run(45, "R8");
        sec = 8'd25; run(45, "R8");
        sec = 8'd1; sel = 1'b1; run(30, "R8");

        // R9/R10 faulted PWM, line A then line B
        sel = 1'b0; md = 3'd7; sec = 8'd7; run(30, "R11");
        fa_n = 1'b0; run(1, "R10");
        fa_n = 1'b1; run(30, "R9");
        fb_n = 1'b0; run(1, "R10");
        fb_n = 1'b1; run(30, "R9");
        md = 3'd6; fa_n = 1'b0; fb_n = 1'b0; run(50, "R10");
        md = 3'd1; pri = 8'd3; run(30, "R10");
        fa_n = 1'b1; fb_n = 1'b1;
        md = 3'd7; run(40, "R11");

        // Random mix
        for (int k = 0; k < 3000; k++) begin
            if ((k % 37) == 0) begin
                md  = 3'($urandom_range(0, 7));
                sel = 1'($urandom_range(0, 1));
                pri = 8'($urandom_range(0, 21));
                sec = 8'($urandom_range(0, 21));
            end
            fa_n = ($urandom_range(0, 60) != 0);
            fb_n = ($urandom_range(0, 60) != 0);
            run(1, "R11");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule